// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine with Selectable Bus Arbitration

This block moves a run of bytes between one I/O device port and main memory, so the CPU does not have to copy each byte itself. Software programs a start address, a byte count, a device number, a direction and an arbitration policy through a small word-addressed register port. It then sets a start bit. The engine requests the shared system bus, moves one byte per granted cycle, and raises a sticky interrupt once the last byte has moved.

Three bus-sharing policies are available at run time. In whole-block mode the bus request is held from the first byte to the last, so the CPU is shut out of memory for the whole transfer. In cycle-stealing mode the engine takes a small unit of bytes per grant, one byte by default, and then drops its request for a cycle so that CPU accesses fall between its own. In idle-slot mode the engine requests and moves data only in cycles where the CPU reports that it is not using the bus.

Register offsets on `cfg_addr`: 0 control, 1 status, 2 address, 3 count, 4 device number. Control fields: bit 0 start, bits 2:1 policy (0 whole-block, 1 cycle-stealing, 2 idle-slot, 3 treated as whole-block), bit 3 direction (0 device-to-memory, 1 memory-to-device), bits 7:4 bytes per grant for cycle-stealing (0 means 1). Status fields: bit 0 busy, bit 1 interrupt flag.

Top module: `dma_mover`

## Requirements
- R1: After reset the busy and interrupt flags are clear, `bus_req` and `irq` are low, and every register reads 0.
- R2: A control write with bit 0 set while idle makes status bit 0 (busy) read 1 from the next cycle, and busy stays set until the last byte has moved.
- R3: With direction 0, each byte that the device offers (`dev_in_valid`) in a transfer cycle is accepted (`dev_in_ready`) and written to memory at the current address. Successive bytes go to successive addresses.
- R4: With direction 1, the memory byte at the current address is offered on `dev_out_data` with `dev_out_valid`. The engine advances only in cycles where `dev_out_ready` is high.
- R5: Each moved byte adds one to the address register and subtracts one from the count register, so after completion the address reads start plus length and the count reads 0.
- R6: Completion sets a sticky interrupt flag (status bit 1, `irq`) that stays set until a status write with bit 1 set clears it. A start with count 0 completes with no memory access.
- R7: Writes to the control, address, count and device registers are ignored while busy.
- R8: In whole-block mode `bus_req` stays high from the start until the last byte has moved.
- R9: In cycle-stealing mode no more than the per-grant unit of bytes moves during one continuous request. After that, `bus_req` drops for at least one cycle before the next request.
- R10: In idle-slot mode `bus_req` is raised, and bytes move, only in cycles where `cpu_busy` is low.
- R11: No memory access happens unless `bus_req` and `bus_gnt` are both high in that cycle.
- R12: `dev_sel` drives the value last written to the device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| cpu_busy | input | 1 | CPU is using the bus this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW (16) | Memory byte address |
| mem_wdata | output | DW (8) | Memory write data |
| mem_rdata | input | DW (8) | Memory read data, same cycle |
| dev_sel | output | DEVW (4) | Selected device number |
| dev_in_valid | input | 1 | Device offers an incoming byte |
| dev_in_data | input | DW (8) | Incoming byte |
| dev_in_ready | output | 1 | Engine accepts the incoming byte |
| dev_out_valid | output | 1 | Engine offers an outgoing byte |
| dev_out_data | output | DW (8) | Outgoing byte |
| dev_out_ready | input | 1 | Device accepts the outgoing byte |

## Verification
The assertions assume that the arbiter grants the bus only to a requester and that `cpu_busy` refers to the same cycle as the grant. They also assume that memory read data for the addressed byte is valid in the cycle it is addressed. The bench ties `bus_grt`-style grant logic directly to `bus_req` behind a gate it can hold closed, models memory with a combinational read port, and derives `cpu_busy` and the device handshakes from a free-running cycle counter. These inputs therefore only ever take values a real arbiter and device could produce.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int UW = 4;  // per-grant unit field width

  typedef enum logic [1:0] {
    ARB_BURST = 2'd0,
    ARB_STEAL = 2'd1,
    ARB_IDLE  = 2'd2,
    ARB_RSVD  = 2'd3
  } arb_mode_e;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_ADDR = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_DEV  = 3'd4;

  // reserved policy code falls back to whole-block
  function automatic arb_mode_e decode_mode(input logic [1:0] code);
    arb_mode_e m;
    case (code)
      2'd1:    m = ARB_STEAL;
      2'd2:    m = ARB_IDLE;
      default: m = ARB_BURST;
    endcase
    return m;
  endfunction

  // bytes per grant in cycle-stealing mode; zero means one
  function automatic logic [UW:0] unit_len(input logic [UW-1:0] field);
    return (field == '0) ? (UW+1)'(1) : {1'b0, field};
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            byte_fire,
  output logic            busy,
  output logic            irq,
  output logic [AW-1:0]   addr_q,
  output logic [CW-1:0]   count_q,
  output arb_mode_e       mode,
  output logic            dir,
  output logic [UW-1:0]   unit,
  output logic [DEVW-1:0] dev_sel
);

  logic wr_ctrl, wr_addr, wr_cnt, wr_dev, clr_irq, finish;

  assign wr_ctrl = cfg_wr && (cfg_addr == OFS_CTRL) && !busy;
  assign wr_addr = cfg_wr && (cfg_addr == OFS_ADDR) && !busy;
  assign wr_cnt  = cfg_wr && (cfg_addr == OFS_CNT)  && !busy;
  assign wr_dev  = cfg_wr && (cfg_addr == OFS_DEV)  && !busy;
  assign clr_irq = cfg_wr && (cfg_addr == OFS_STAT) && cfg_wdata[1];
  assign finish  = busy && ((count_q == '0) ||
                            (byte_fire && count_q == CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      irq     <= 1'b0;
      addr_q  <= '0;
      count_q <= '0;
      mode    <= ARB_BURST;
      dir     <= 1'b0;
      unit    <= '0;
      dev_sel <= '0;
    end else begin
      if (wr_ctrl) begin
        mode <= decode_mode(cfg_wdata[2:1]);
        dir  <= cfg_wdata[3];
        unit <= cfg_wdata[4 +: UW];
      end
      if (wr_ctrl && cfg_wdata[0]) busy <= 1'b1;
      else if (finish)             busy <= 1'b0;

      if (wr_addr)        addr_q <= AW'(cfg_wdata);
      else if (byte_fire) addr_q <= addr_q + AW'(1);

      if (wr_cnt)         count_q <= CW'(cfg_wdata);
      else if (byte_fire) count_q <= count_q - CW'(1);

      if (wr_dev) dev_sel <= cfg_wdata[DEVW-1:0];

      if (finish)       irq <= 1'b1;
      else if (clr_irq) irq <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL: cfg_rdata = 32'({unit, dir, mode, 1'b0});
      OFS_STAT: cfg_rdata = 32'({irq, busy});
      OFS_ADDR: cfg_rdata = 32'(addr_q);
      OFS_CNT:  cfg_rdata = 32'(count_q);
      OFS_DEV:  cfg_rdata = 32'(dev_sel);
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_bus_ctl.sv
module dma_bus_ctl
  import dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          count_nz,
  input  arb_mode_e     mode,
  input  logic [UW-1:0] unit,
  input  logic          cpu_busy,
  input  logic          byte_fire,
  output logic          bus_req,
  output logic          grant_end
);

  logic          gap_q;
  logic [UW:0]   run_q;
  logic [UW:0]   run_nx;
  logic          mode_ok;

  assign mode_ok   = (mode != ARB_IDLE) || !cpu_busy;
  assign bus_req   = busy && count_nz && !gap_q && mode_ok;
  assign run_nx    = run_q + (UW+1)'(1);
  assign grant_end = byte_fire && (mode == ARB_STEAL) &&
                     (run_nx >= unit_len(unit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      run_q <= '0;
    end else if (!busy) begin
      gap_q <= 1'b0;
      run_q <= '0;
    end else if (gap_q) begin
      gap_q <= 1'b0;
    end else if (grant_end) begin
      gap_q <= 1'b1;
      run_q <= '0;
    end else if (byte_fire && mode == ARB_STEAL) begin
      run_q <= run_nx;
    end
  end

endmodule

// File: rtl/dma_byte_path.sv
module dma_byte_path #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          bus_req,
  input  logic          bus_gnt,
  input  logic          dir,
  input  logic [AW-1:0] addr_q,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          slot,
  output logic          byte_fire
);

  assign slot          = bus_req && bus_gnt;
  assign dev_in_ready  = slot && !dir && dev_in_valid;
  assign dev_out_valid = slot && dir;
  assign dev_out_data  = mem_rdata;
  assign byte_fire     = dir ? (slot && dev_out_ready) : dev_in_ready;

  assign mem_en    = dir ? slot : dev_in_ready;
  assign mem_we    = !dir && dev_in_ready;
  assign mem_addr  = addr_q;
  assign mem_wdata = dev_in_data;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 8,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            irq,
  output logic            bus_req,
  input  logic            bus_gnt,
  input  logic            cpu_busy,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DEVW-1:0] dev_sel,
  input  logic            dev_in_valid,
  input  logic [DW-1:0]   dev_in_data,
  output logic            dev_in_ready,
  output logic            dev_out_valid,
  output logic [DW-1:0]   dev_out_data,
  input  logic            dev_out_ready
);

  // named internal events for the checker
  logic          busy;
  logic          byte_fire;
  logic          slot;
  logic          grant_end;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  arb_mode_e     mode;
  logic          dir;
  logic [UW-1:0] unit;

  dma_regs #(.AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .byte_fire(byte_fire),
    .busy(busy), .irq(irq), .addr_q(addr_q), .count_q(count_q),
    .mode(mode), .dir(dir), .unit(unit), .dev_sel(dev_sel)
  );

  dma_bus_ctl u_bus (
    .clk(clk), .rst_n(rst_n), .busy(busy), .count_nz(count_q != '0),
    .mode(mode), .unit(unit), .cpu_busy(cpu_busy),
    .byte_fire(byte_fire), .bus_req(bus_req), .grant_end(grant_end)
  );

  dma_byte_path #(.AW(AW), .DW(DW)) u_path (
    .bus_req(bus_req), .bus_gnt(bus_gnt), .dir(dir), .addr_q(addr_q),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .slot(slot), .byte_fire(byte_fire)
  );

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          cpu_busy,
  input logic          mem_en,
  input logic          mem_we,
  input logic          dev_in_ready,
  input logic          dev_out_valid,
  input logic          dev_out_ready,
  input logic          byte_fire,
  input logic          busy,
  input logic          irq,
  input arb_mode_e     mode,
  input logic [UW-1:0] unit,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] count_q
);

  logic [UW+1:0] run_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_c <= '0;
    else if (!bus_req)  run_c <= '0;
    else if (byte_fire) run_c <= run_c + (UW+2)'(1);
  end

  assert_bus_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (bus_req && bus_gnt));

  assert_idle_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_IDLE && cpu_busy) |-> (!mem_en && !bus_req));

  assert_steal_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == ARB_STEAL) |-> (run_c <= (UW+2)'(unit_len(unit))));

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == ARB_BURST && count_q != '0) |-> bus_req);

  assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_fire) |=> ($stable(addr_q) && $stable(count_q)));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |=> (count_q == $past(count_q) - CW'(1)));

  assert_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready |-> (mem_en && mem_we));

  assert_out_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> $stable(addr_q));

endmodule

bind dma_mover dma_mover_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dma_mover_bench.sv
`timescale 1ns/1ps
module dma_mover_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, bus_gnt, cpu_busy;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [3:0]  dev_sel;
  logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [7:0]  dev_in_data, dev_out_data;

  always #2 clk = ~clk;  // 250 MHz

  dma_mover u_dma_mover (.*);

  // bench environment
  logic [7:0] mem [256];
  logic [7:0] outbuf [64];
  int  cyc = 0, in_idx = 0, out_n = 0, seed = 0;
  int  fires = 0, busy_fires = 0, req_low = 0, run = 0, maxrun = 0, mem_hits = 0;
  logic fired_any = 1'b0, clr = 1'b0, gnt_en = 1'b1;
  int  bp_sel = 0, rp_sel = 0;
  int  n_tests = 0, n_fail = 0;
  logic finished = 1'b0;

  function automatic logic bpat(input int s, input int c);
    case (s)
      1: return (c % 2) == 1;
      2: return (c % 3) != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic rpat(input int s, input int c);
    case (s)
      1: return (c % 2) == 0;
      2: return (c % 3) == 0;
      default: return 1'b1;
    endcase
  endfunction

  assign bus_gnt       = bus_req && gnt_en;
  assign cpu_busy      = bpat(bp_sel, cyc);
  assign dev_in_valid  = rpat(rp_sel, cyc);
  assign dev_out_ready = rpat(rp_sel, cyc);
  assign dev_in_data   = 8'(in_idx * 3 + seed);
  assign mem_rdata     = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    logic f;
    f = (mem_en && mem_we) || (dev_out_valid && dev_out_ready);
    cyc <= cyc + 1;
    if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (clr) begin
      in_idx <= 0; out_n <= 0; fires <= 0; busy_fires <= 0;
      req_low <= 0; run <= 0; maxrun <= 0; mem_hits <= 0; fired_any <= 1'b0;
    end else begin
      if (dev_in_valid && dev_in_ready) in_idx <= in_idx + 1;
      if (dev_out_valid && dev_out_ready) begin
        outbuf[out_n[5:0]] <= dev_out_data;
        out_n <= out_n + 1;
      end
      if (mem_en) mem_hits <= mem_hits + 1;
      if (f) begin
        fires <= fires + 1;
        fired_any <= 1'b1;
        if (cpu_busy) busy_fires <= busy_fires + 1;
      end
      if (fired_any && !irq && !bus_req) req_low <= req_low + 1;
      if (!bus_req) run <= 0;
      else if (f) begin
        run <= run + 1;
        if (run + 1 > maxrun) maxrun <= run + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int t;
    t = 0;
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    check(irq == 1'b1, tag, int'(irq), 1);
  endtask

  typedef struct packed {
    logic       dir;
    logic [1:0] mode;
    logic [3:0] unit;
    logic [7:0] addr;
    logic [7:0] len;
    logic [1:0] bp;
    logic [1:0] rp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 2'd0, 4'd0, 8'h10, 8'd12, 2'd0, 2'd0},
    '{1'b1, 2'd0, 4'd0, 8'h30, 8'd9,  2'd0, 2'd1},
    '{1'b0, 2'd1, 4'd1, 8'h50, 8'd10, 2'd0, 2'd0},
    '{1'b1, 2'd1, 4'd3, 8'h70, 8'd14, 2'd0, 2'd2},
    '{1'b0, 2'd2, 4'd0, 8'h90, 8'd11, 2'd1, 2'd0},
    '{1'b1, 2'd2, 4'd0, 8'hB0, 8'd13, 2'd2, 2'd1},
    '{1'b0, 2'd1, 4'd0, 8'hD0, 8'd5,  2'd2, 2'd0}
  };

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), rv);
      check(rv == 0, "R1 register reads zero after reset", int'(rv), 0);
    end
    check(!irq && !bus_req, "R1 irq and bus_req low after reset",
          int'({irq, bus_req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reg_rd(3'd1, rv);
    check(rv == 0, "R1 status clear after release", int'(rv), 0);

    // table-driven transfers
    for (int v = 0; v < 7; v++) begin
      int ulen, ok;
      vec_t t;
      t = VECS[v];
      seed = v * 16 + 5;
      ulen = (t.unit == 0) ? 1 : int'(t.unit);
      bp_sel = int'(t.bp); rp_sel = int'(t.rp);
      for (int i = 0; i < int'(t.len); i++) mem[8'(int'(t.addr) + i)] = 8'(i * 7 + seed);
      clear_mon();
      reg_wr(3'd2, 32'(t.addr));
      reg_wr(3'd3, 32'(t.len));
      reg_wr(3'd0, {24'd0, t.unit, t.dir, t.mode, 1'b1});
      reg_rd(3'd1, rv);
      check(rv[0] == 1'b1, "R2 busy set after start", int'(rv[0]), 1);
      wait_irq("R6 irq after transfer");
      ok = 1;
      for (int i = 0; i < int'(t.len); i++) begin
        if (t.dir == 1'b0) begin
          if (mem[8'(int'(t.addr) + i)] != 8'(i * 3 + seed)) ok = 0;
        end else begin
          if (outbuf[i] != 8'(i * 7 + seed)) ok = 0;
        end
      end
      if (t.dir == 1'b0) check(ok == 1, "R3 incoming bytes in memory", ok, 1);
      else check(ok == 1 && out_n == int'(t.len), "R4 outgoing byte stream", out_n, int'(t.len));
      check(fires == int'(t.len), "R5 byte count moved", fires, int'(t.len));
      reg_rd(3'd2, rv);
      check(rv == 32'(int'(t.addr) + int'(t.len)), "R5 final address", int'(rv),
            int'(t.addr) + int'(t.len));
      reg_rd(3'd3, rv);
      check(rv == 0, "R5 final count", int'(rv), 0);
      case (t.mode)
        2'd0: check(req_low == 0, "R8 request held through block", req_low, 0);
        2'd1: begin
          check(maxrun <= ulen, "R9 bytes per grant", maxrun, ulen);
          check(req_low > 0, "R9 request released between grants", req_low, 1);
        end
        default: check(busy_fires == 0, "R10 no move while cpu busy", busy_fires, 0);
      endcase
      reg_rd(3'd1, rv);
      check(rv == 2, "R6 status after done", int'(rv), 2);
      repeat (4) @(negedge clk);
      check(irq == 1'b1, "R6 irq sticky", int'(irq), 1);
      reg_wr(3'd1, 32'h2);
      #1 check(irq == 1'b0, "R6 irq cleared by status write", int'(irq), 0);
    end
    bp_sel = 0; rp_sel = 0;

    // R6: zero-length start
    clear_mon();
    reg_wr(3'd3, 32'd0);
    reg_wr(3'd0, 32'h1);
    wait_irq("R6 zero length completes");
    check(mem_hits == 0, "R6 zero length no memory access", mem_hits, 0);
    reg_wr(3'd1, 32'h2);

    // R7 / R11: stalled grant, writes ignored while busy
    seed = 200;
    clear_mon();
    gnt_en = 1'b0;
    reg_wr(3'd2, 32'hE0);
    reg_wr(3'd3, 32'd8);
    reg_wr(3'd0, 32'h1);
    repeat (10) @(negedge clk);
    reg_rd(3'd1, rv);
    check(rv[0] == 1'b1, "R2 busy while waiting for grant", int'(rv[0]), 1);
    reg_wr(3'd2, 32'h05);
    reg_wr(3'd3, 32'd3);
    reg_wr(3'd0, 32'h3C);
    reg_wr(3'd4, 32'd7);
    reg_rd(3'd2, rv);
    check(rv == 32'hE0, "R7 address write ignored", int'(rv), 32'hE0);
    reg_rd(3'd3, rv);
    check(rv == 8, "R7 count write ignored", int'(rv), 8);
    reg_rd(3'd0, rv);
    check(rv == 0, "R7 control write ignored", int'(rv), 0);
    check(dev_sel == 4'd0, "R7 device write ignored", int'(dev_sel), 0);
    check(mem_hits == 0, "R11 no access without grant", mem_hits, 0);
    gnt_en = 1'b1;
    wait_irq("R6 irq after stalled transfer");
    reg_rd(3'd2, rv);
    check(rv == 32'hE8, "R7 address advanced from original", int'(rv), 32'hE8);
    check(mem[8'hE7] == 8'(7 * 3 + 200), "R3 last byte of stalled transfer",
          int'(mem[8'hE7]), int'(8'(7 * 3 + 200)));
    reg_wr(3'd1, 32'h2);

    // R12: device number
    reg_wr(3'd4, 32'd9);
    #1 check(dev_sel == 4'd9, "R12 device select output", int'(dev_sel), 9);
    reg_rd(3'd4, rv);
    check(rv == 9, "R12 device register readback", int'(rv), 9);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule